// File: doc/BRIEF.md
# Dual Interval Timer Register Window

This block puts two identical down-counting interval timers behind one 4 KB register window on a simple word-addressed register bus. The bus presents a 12-bit byte address, a write strobe and 32-bit write data; read data is returned combinationally for whatever address is presented. The window has four kinds of region. The lowest 32 bytes reach the first timer. The next 32 bytes reach the second timer, with the region base taken off before the sub-timer sees the offset. The topmost 32 bytes are a read-only table of identification bytes. Everything else, including the two integration-test slots at 0xF00 and 0xF04, reads as zero and ignores writes.

Each timer advances only on its own tick input. The tick is a single-cycle enable pulse in the bus clock domain, so the two timers can run from unrelated rates. The interrupt lines of the two timers are merged into one interrupt output. Inside each timer a three-state machine governs counting. ST_IDLE means stopped. ST_RUN means counting. ST_HALT means a one-shot count has finished. The transitions are as follows. ST_IDLE goes to ST_RUN on a control write with the enable bit set. ST_RUN goes to ST_IDLE on a control write with enable clear. ST_RUN goes to ST_HALT when a one-shot count expires. ST_HALT goes to ST_RUN or to ST_IDLE on a control write, according to its enable bit. ST_HALT also goes to ST_RUN on a load write while enabled. A bus write in the same cycle as a tick takes precedence over the tick.

Top module: `dual_timer_window`

## Requirements
- R1: Byte offsets 0x00-0x1F select the first timer and offsets 0x20-0x3F select the second timer, at offset minus 0x20. Within either timer, word index 0 is the load register, 1 is the current count (read-only), 2 is control, 3 is interrupt clear (write-only), 4 is the raw interrupt flag, 5 is the masked interrupt flag and 6 is the background load register. A read of index 6 returns the load register.
- R2: Offsets 0xFE0-0xFFC return one identification byte per word in bits 7:0, with bits 31:8 zero. The table index is (offset-0xFE0)>>2, and the bytes in index order are 0x04, 0x18, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R3: irq_out is high exactly when either timer's masked interrupt is high.
- R4: Reads of 0xF00, 0xF04 and of every offset outside R1 and R2 return 0. Writes to any offset outside R1 have no effect.
- R5: After reset, each timer has control 0x20, load 0, count 0xFFFF and both interrupt flags 0, and irq_out is 0.
- R6: A load write sets both the reload value and the current count. A background load write sets only the reload value.
- R7: Control bit 7 enables counting, bit 6 selects periodic reload and bit 0 selects one-shot, which takes priority over bit 6. A qualified tick on a nonzero count decrements it. A qualified tick on a zero count sets the raw flag and then does one of three things: in one-shot mode it holds the count at 0 and stops further counting; in periodic mode it reloads from the load register; otherwise it reloads the all-ones maximum.
- R8: Control bits 3:2 select the tick prescale. Code 0 qualifies every tick, code 1 qualifies every 16th tick and codes 2 and 3 qualify every 256th tick. The prescale restarts on a control write.
- R9: A write to the interrupt clear index clears the raw flag. The masked flag is the raw flag ANDed with control bit 5.
- R10: tick_a advances only the first timer and tick_b advances only the second.
- R11: Control bit 1 clear selects 16-bit mode. In 16-bit mode the count and load are truncated to 16 bits and the free-running reload is 0xFFFF. With bit 1 set, the full 32 bits are used.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 12 | Byte address within the window |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| tick_a | input | 1 | Count tick for the first timer |
| tick_b | input | 1 | Count tick for the second timer |
| irq_out | output | 1 | Merged interrupt |

## Verification
The bench first targets the address split. A decoder that failed to remove the 0x20 base, or that let the two ranges overlap, would show one timer's registers changing when the other timer is written. Tick crossing is checked next: a shared or swapped tick would move the idle timer's count. A one-shot timer gets ticks after it expires, because a design that reloaded or wrapped there would show a nonzero count or would keep setting its flag. The prescale is checked on its 15th/16th and 255th/256th tick, where an off-by-one divider moves the count one tick early or late. 16-bit truncation and the 0xFFFF free-running reload catch a design that keeps the upper bits. The identification bytes are read back after stray writes to the table and to the test slots, which a design that let those writes through would alter.

// File: rtl/dtw_pkg.sv
package dtw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HALT = 2'd2
    } tmr_state_t;

    typedef enum logic [2:0] {
        IDX_LOAD  = 3'd0,
        IDX_COUNT = 3'd1,
        IDX_CTRL  = 3'd2,
        IDX_CLEAR = 3'd3,
        IDX_RAW   = 3'd4,
        IDX_MASK  = 3'd5,
        IDX_BGLD  = 3'd6
    } reg_idx_t;

    localparam logic [7:0] CTRL_RESET = 8'h20;

    function automatic logic [7:0] ident_byte(input logic [2:0] idx);
        logic [7:0] b;
        unique case (idx)
            3'd0: b = 8'h04;
            3'd1: b = 8'h18;
            3'd2: b = 8'h14;
            3'd3: b = 8'h00;
            3'd4: b = 8'h0D;
            3'd5: b = 8'hF0;
            3'd6: b = 8'h05;
            default: b = 8'hB1;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/dtw_timer.sv
module dtw_timer
    import dtw_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       reg_idx,
    input  logic [CNT_W-1:0] wdata,
    input  logic             tick,
    output logic [CNT_W-1:0] rdata,
    output logic             irq
);
    localparam int NARROW_W = 16;
    localparam logic [CNT_W-1:0] NARROW_MAX = {{(CNT_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
    localparam logic [CNT_W-1:0] WIDE_MAX   = {CNT_W{1'b1}};

    tmr_state_t       state, nxt_state;
    logic [7:0]       ctrl;
    logic [CNT_W-1:0] load_r;
    logic [CNT_W-1:0] count;
    logic             raw;
    logic [PRE_W-1:0] pre;

    logic one_shot, wide, ie, periodic, enable;
    logic [1:0] div_sel;
    logic qualified, step, at_zero;
    logic wr_load, wr_ctrl, wr_bg, wr_clr;

    assign one_shot = ctrl[0];
    assign wide     = ctrl[1];
    assign div_sel  = ctrl[3:2];
    assign ie       = ctrl[5];
    assign periodic = ctrl[6];
    assign enable   = ctrl[7];

    assign wr_load = wr_en && (reg_idx == IDX_LOAD);
    assign wr_ctrl = wr_en && (reg_idx == IDX_CTRL);
    assign wr_bg   = wr_en && (reg_idx == IDX_BGLD);
    assign wr_clr  = wr_en && (reg_idx == IDX_CLEAR);

    function automatic logic [CNT_W-1:0] fit(input logic [CNT_W-1:0] v, input logic w);
        return w ? v : (v & NARROW_MAX);
    endfunction

    always_comb begin
        unique case (div_sel)
            2'd0:    qualified = 1'b1;
            2'd1:    qualified = (pre[3:0] == 4'hF);
            default: qualified = (pre == {PRE_W{1'b1}});
        endcase
    end

    assign step    = tick && (state == ST_RUN) && qualified && !wr_en;
    assign at_zero = (count == '0);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt_state;
    end

    // next-state logic
    always_comb begin
        nxt_state = state;
        unique case (state)
            ST_IDLE: if (wr_ctrl && wdata[7]) nxt_state = ST_RUN;
            ST_RUN: begin
                if (wr_ctrl && !wdata[7])             nxt_state = ST_IDLE;
                else if (step && at_zero && one_shot) nxt_state = ST_HALT;
            end
            ST_HALT: begin
                if (wr_ctrl)                nxt_state = wdata[7] ? ST_RUN : ST_IDLE;
                else if (wr_load && enable) nxt_state = ST_RUN;
            end
            default: nxt_state = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl   <= CTRL_RESET;
            load_r <= '0;
            count  <= NARROW_MAX;
            raw    <= 1'b0;
            pre    <= '0;
        end else if (wr_en) begin
            if (wr_load) begin
                load_r <= fit(wdata, wide);
                count  <= fit(wdata, wide);
            end
            if (wr_bg) load_r <= fit(wdata, wide);
            if (wr_clr) raw <= 1'b0;
            if (wr_ctrl) begin
                ctrl   <= wdata[7:0];
                pre    <= '0;
                count  <= fit(count, wdata[1]);
                load_r <= fit(load_r, wdata[1]);
            end
        end else if (tick && state == ST_RUN) begin
            pre <= pre + 1'b1;
            if (step) begin
                if (at_zero) begin
                    raw <= 1'b1;
                    if (one_shot)      count <= count;
                    else if (periodic) count <= load_r;
                    else               count <= wide ? WIDE_MAX : NARROW_MAX;
                end else begin
                    count <= count - 1'b1;
                end
            end
        end
    end

    // outputs
    always_comb begin
        rdata = '0;
        case (reg_idx)
            IDX_LOAD, IDX_BGLD: rdata = load_r;
            IDX_COUNT:          rdata = count;
            IDX_CTRL:           rdata = {{(CNT_W-8){1'b0}}, ctrl};
            IDX_RAW:            rdata = {{(CNT_W-1){1'b0}}, raw};
            IDX_MASK:           rdata = {{(CNT_W-1){1'b0}}, raw & ie};
            default:            rdata = '0;
        endcase
        irq = raw && ie;
    end

    // R7: a qualified tick on a nonzero count lowers it by exactly one
    a_r7_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !at_zero) |=> (count == $past(count) - 1'b1));

    // R7: an expired one-shot count does not move without a bus write
    a_r7_halt_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT && !wr_en) |=> $stable(count));

    // R9: a clear write leaves the raw flag low
    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> !raw);

    // R11: in 16-bit mode the upper count bits stay zero
    a_r11_narrow: assert property (@(posedge clk) disable iff (!rst_n)
        !wide |-> (count[CNT_W-1:NARROW_W] == '0));

endmodule

// File: rtl/dtw_decode.sv
module dtw_decode #(
    parameter int ADDR_W   = 12,
    parameter int SLOT_W   = 5,
    parameter int N_TIMERS = 2
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic [N_TIMERS-1:0] tmr_sel,
    output logic                id_hit,
    output logic [2:0]          word_idx
);
    localparam int SLOT_BITS = ADDR_W - SLOT_W;
    localparam logic [SLOT_BITS-1:0] ID_SLOT = {SLOT_BITS{1'b1}};

    logic [SLOT_BITS-1:0] slot;
    assign slot     = addr[ADDR_W-1:SLOT_W];
    assign word_idx = addr[SLOT_W-1:2];
    assign id_hit   = (slot == ID_SLOT);

    for (genvar i = 0; i < N_TIMERS; i++) begin : g_sel
        assign tmr_sel[i] = (slot == SLOT_BITS'(i));
    end

endmodule

// File: rtl/dual_timer_window.sv
module dual_timer_window
    import dtw_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tick_a,
    input  logic              tick_b,
    output logic              irq_out
);
    localparam int N_TIMERS = 2;

    logic [N_TIMERS-1:0] tmr_sel;
    logic [N_TIMERS-1:0] tmr_irq;
    logic [N_TIMERS-1:0] tick_v;
    logic [DATA_W-1:0]   tmr_rd [N_TIMERS];
    logic                id_hit;
    logic [2:0]          word_idx;

    assign tick_v = {tick_b, tick_a};

    dtw_decode #(
        .ADDR_W  (ADDR_W),
        .SLOT_W  (5),
        .N_TIMERS(N_TIMERS)
    ) u_decode (
        .addr    (bus_addr),
        .tmr_sel (tmr_sel),
        .id_hit  (id_hit),
        .word_idx(word_idx)
    );

    for (genvar i = 0; i < N_TIMERS; i++) begin : g_tmr
        dtw_timer #(
            .CNT_W(DATA_W),
            .PRE_W(8)
        ) u_tmr (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (bus_wr && tmr_sel[i]),
            .reg_idx(word_idx),
            .wdata  (bus_wdata),
            .tick   (tick_v[i]),
            .rdata  (tmr_rd[i]),
            .irq    (tmr_irq[i])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (tmr_sel[0])      bus_rdata = tmr_rd[0];
        else if (tmr_sel[1]) bus_rdata = tmr_rd[1];
        else if (id_hit)     bus_rdata = {{(DATA_W-8){1'b0}}, ident_byte(word_idx)};
    end

    assign irq_out = |tmr_irq;

    // R3: merged line follows the timer lines
    a_r3_irq_merge: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == ($countones(tmr_irq) != 0));

    // R2: identification words carry only a byte
    a_r2_id_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[ADDR_W-1:5] == '1) |-> (bus_rdata[DATA_W-1:8] == '0));

    // R4: unmapped space reads zero
    a_r4_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_addr[ADDR_W-1:6] != '0) && (bus_addr[ADDR_W-1:5] != '1)) |-> (bus_rdata == '0));

    // R5: no interrupt straight after reset
    a_r5_quiet_after_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> !irq_out);

endmodule

// File: tb/dual_timer_window_tb.sv
module dual_timer_window_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tick_a = 1'b0;
    logic        tick_b = 1'b0;
    logic        irq_out;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dual_timer_window u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_a(tick_a),
        .tick_b(tick_b), .irq_out(irq_out)
    );

    // address, expected read, requirement code (2, 4 or 5)
    typedef struct packed { logic [11:0] a; logic [31:0] e; logic [3:0] r; } vec_t;
    localparam int NV = 19;
    localparam vec_t VEC [NV] = '{
        '{12'h000, 32'h0,    4'd5}, '{12'h004, 32'hFFFF, 4'd5}, '{12'h008, 32'h20, 4'd5},
        '{12'h010, 32'h0,    4'd5}, '{12'h014, 32'h0,    4'd5}, '{12'h024, 32'hFFFF, 4'd5},
        '{12'h028, 32'h20,   4'd5},
        '{12'hFE0, 32'h04,   4'd2}, '{12'hFE4, 32'h18,   4'd2}, '{12'hFE8, 32'h14, 4'd2},
        '{12'hFEC, 32'h00,   4'd2}, '{12'hFF0, 32'h0D,   4'd2}, '{12'hFF4, 32'hF0, 4'd2},
        '{12'hFF8, 32'h05,   4'd2}, '{12'hFFC, 32'hB1,   4'd2},
        '{12'hF00, 32'h0,    4'd4}, '{12'hF04, 32'h0,    4'd4}, '{12'h040, 32'h0,  4'd4},
        '{12'h800, 32'h0,    4'd4}
    };

    function automatic string tag_of(input logic [3:0] r);
        case (r)
            4'd2:    return "R2";
            4'd4:    return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        bus_addr = a;
        #2;
        check(req, bus_rdata, exp);
    endtask

    task automatic pulse(input bit which_b, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (which_b) tick_b = 1'b1; else tick_a = 1'b1;
            @(negedge clk);
            tick_a = 1'b0; tick_b = 1'b0;
        end
    endtask

    task automatic irq_is(input logic exp, input string req);
        @(negedge clk);
        #2;
        check(req, {31'b0, irq_out}, {31'b0, exp});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // reset values, identification table, unmapped reads
        for (int i = 0; i < NV; i++) rd(VEC[i].a, VEC[i].e, tag_of(VEC[i].r));
        irq_is(1'b0, "R5");

        // R1 R6: first timer programmed, second untouched
        wr(12'h000, 32'd3);
        wr(12'h008, 32'hE2);
        rd(12'h004, 32'd3, "R6");
        rd(12'h024, 32'hFFFF, "R1");
        rd(12'h020, 32'h0, "R1");

        // R7 periodic reload and flag
        pulse(1'b0, 1);
        rd(12'h004, 32'd2, "R7");
        pulse(1'b0, 3);
        rd(12'h004, 32'd3, "R7");
        rd(12'h010, 32'd1, "R7");
        rd(12'h014, 32'd1, "R9");
        irq_is(1'b1, "R3");
        wr(12'h00C, 32'd0);
        rd(12'h010, 32'd0, "R9");
        irq_is(1'b0, "R3");

        // R9 masked flag with interrupt enable off
        wr(12'h000, 32'd0);
        wr(12'h008, 32'hC2);
        pulse(1'b0, 1);
        rd(12'h010, 32'd1, "R9");
        rd(12'h014, 32'd0, "R9");
        irq_is(1'b0, "R3");
        wr(12'h00C, 32'd0);
        wr(12'h008, 32'h00);

        // R10 R7 one-shot on the second timer
        wr(12'h020, 32'd1);
        wr(12'h028, 32'hA3);
        pulse(1'b0, 2);
        rd(12'h024, 32'd1, "R10");
        pulse(1'b1, 2);
        rd(12'h024, 32'd0, "R7");
        rd(12'h030, 32'd1, "R7");
        irq_is(1'b1, "R3");
        pulse(1'b1, 3);
        rd(12'h024, 32'd0, "R7");
        wr(12'h02C, 32'd0);
        irq_is(1'b0, "R3");

        // R8 prescale by 16 then by 256
        wr(12'h008, 32'hE6);
        wr(12'h000, 32'd10);
        pulse(1'b0, 15);
        rd(12'h004, 32'd10, "R8");
        pulse(1'b0, 1);
        rd(12'h004, 32'd9, "R8");
        wr(12'h008, 32'hEA);
        pulse(1'b0, 255);
        rd(12'h004, 32'd9, "R8");
        pulse(1'b0, 1);
        rd(12'h004, 32'd8, "R8");

        // R11 16-bit mode, free-running reload
        wr(12'h008, 32'hA0);
        wr(12'h000, 32'h12345);
        rd(12'h004, 32'h2345, "R11");
        rd(12'h000, 32'h2345, "R11");
        wr(12'h000, 32'd0);
        pulse(1'b0, 1);
        rd(12'h004, 32'hFFFF, "R11");
        wr(12'h00C, 32'd0);

        // R6 background load
        wr(12'h008, 32'hE2);
        wr(12'h000, 32'd2);
        wr(12'h018, 32'd7);
        rd(12'h004, 32'd2, "R6");
        rd(12'h018, 32'd7, "R6");
        rd(12'h000, 32'd7, "R1");
        pulse(1'b0, 3);
        rd(12'h004, 32'd7, "R6");
        wr(12'h00C, 32'd0);

        // R4 stray writes have no effect
        wr(12'hF00, 32'hFF);
        wr(12'h040, 32'h55);
        wr(12'hFE0, 32'h77);
        rd(12'hFE0, 32'h04, "R4");
        rd(12'hF00, 32'h0, "R4");
        rd(12'h000, 32'd7, "R4");
        rd(12'h020, 32'd1, "R4");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule